// File: doc/BRIEF.md
# Bidirectional Timer Counter Core

This block is the counting heart of a general-purpose timer. It holds an up/down counter that moves only on cycles where a timer-tick enable is present and a non-zero clock-select code is applied. On such a cycle a control block can ask it to clear, to step up by one or to step down by one. The prescaler, the oscillator and the waveform sequencing that picks the direction all sit outside the block. Here they are plain inputs.

A host bus port can read the counter value at any moment, even while ticks are stopped. A host write loads a new value and beats any clear or count request in the same cycle. Two outputs flag the counter at its maximum and at zero, for use by later compare and waveform logic. An overflow flag records an upward wrap from the maximum value to zero. It can raise an interrupt request, and it is cleared either by the host writing a one to its bit or by an interrupt-acknowledge pulse.

Top module: `updown_timer_core`

## Requirements
- R1: After reset the counter reads 0, bottom_o is 1, top_o is 0, and the overflow flag and irq_o are 0.
- R2: When host_wr_i is 1, the counter holds host_wdata_i from the next cycle on. host_rdata_o always shows the current counter value, with or without ticks.
- R3: A host write beats a clear or a count request in the same cycle, even when the tick is enabled.
- R4: When clk_sel_i is 0, tick_i has no effect. The counter holds even when count_i or clear_i is 1.
- R5: On an enabled tick with count_i=1, clear_i=0 and dir_up_i=1, the counter rises by one. From the maximum value (2^WIDTH-1) it wraps to 0.
- R6: On an enabled tick with count_i=1, clear_i=0 and dir_up_i=0, the counter falls by one. From 0 it wraps to the maximum value.
- R7: On an enabled tick with clear_i=1, the counter becomes 0, whatever count_i and dir_up_i are.
- R8: top_o is 1 exactly when the counter holds the maximum value. bottom_o is 1 exactly when it holds 0.
- R9: The overflow flag sets in the cycle after an upward wrap from the maximum value to 0. A downward wrap, a clear or a host load does not set it.
- R10: A pulse on flag_clr_i or irq_ack_i clears the flag on the next cycle. If a wrap happens in that same cycle, the set wins.
- R11: irq_o equals the overflow flag ANDed with irq_en_i.
- R12: When tick_i is 0, the counter holds whatever clk_sel_i, count_i and clear_i are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle timer tick enable |
| clk_sel_i | input | SEL_W | Clock-source select; zero stops the timer |
| count_i | input | 1 | Count request |
| dir_up_i | input | 1 | 1 = count up, 0 = count down |
| clear_i | input | 1 | Clear request |
| host_wr_i | input | 1 | Host write strobe for the counter |
| host_wdata_i | input | WIDTH | Host write value |
| host_rdata_o | output | WIDTH | Current counter value |
| flag_clr_i | input | 1 | Host write-one-to-clear of the overflow flag |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_en_i | input | 1 | Overflow interrupt enable |
| top_o | output | 1 | Counter at maximum value |
| bottom_o | output | 1 | Counter at zero |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its defaults, WIDTH=8 and SEL_W=3. Both wrap points, 255 to 0 and 0 to 255, are therefore reachable with a single host load followed by one or two ticks, and the full 8-bit value range is exercised. With a 3-bit select field, the bench can show that every one of the seven non-zero codes lets ticks through and that code zero blocks them.

// File: rtl/timer_core_pkg.sv
package timer_core_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_CLEAR = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } cnt_op_e;
endpackage

// File: rtl/timer_op_decode.sv
module timer_op_decode
  import timer_core_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             tick_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             count_i,
  input  logic             dir_up_i,
  input  logic             clear_i,
  input  logic             host_wr_i,
  output cnt_op_e          op_o
);
  logic tick_en;
  assign tick_en = tick_i && (clk_sel_i != '0);

  // priority: host load, then clear, then count
  always_comb begin
    op_o = OP_HOLD;
    if (host_wr_i)             op_o = OP_LOAD;
    else if (tick_en) begin
      if (clear_i)             op_o = OP_CLEAR;
      else if (count_i)        op_o = dir_up_i ? OP_INC : OP_DEC;
    end
  end
endmodule

// File: rtl/timer_cnt_reg.sv
module timer_cnt_reg
  import timer_core_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             top_o,
  output logic             bottom_o,
  output logic             wrap_up_o
);
  localparam logic [WIDTH-1:0] CntMax = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case (op_i)
      OP_LOAD:  cnt_d = load_val_i;
      OP_CLEAR: cnt_d = '0;
      OP_INC:   cnt_d = cnt_q + 1'b1;
      OP_DEC:   cnt_d = cnt_q - 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign top_o     = (cnt_q == CntMax);
  assign bottom_o  = (cnt_q == '0);
  assign wrap_up_o = (op_i == OP_INC) && (cnt_q == CntMax);
endmodule

// File: rtl/timer_ovf_flag.sv
module timer_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // a new wrap is never lost to a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/updown_timer_core.sv
module updown_timer_core
  import timer_core_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             count_i,
  input  logic             dir_up_i,
  input  logic             clear_i,
  input  logic             host_wr_i,
  input  logic [WIDTH-1:0] host_wdata_i,
  output logic [WIDTH-1:0] host_rdata_o,
  input  logic             flag_clr_i,
  input  logic             irq_ack_i,
  input  logic             irq_en_i,
  output logic             top_o,
  output logic             bottom_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  cnt_op_e op;
  logic    wrap_up;

  timer_op_decode #(.SEL_W(SEL_W)) u_decode (
    .tick_i    (tick_i),
    .clk_sel_i (clk_sel_i),
    .count_i   (count_i),
    .dir_up_i  (dir_up_i),
    .clear_i   (clear_i),
    .host_wr_i (host_wr_i),
    .op_o      (op)
  );

  timer_cnt_reg #(.WIDTH(WIDTH)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .load_val_i (host_wdata_i),
    .cnt_o      (host_rdata_o),
    .top_o      (top_o),
    .bottom_o   (bottom_o),
    .wrap_up_o  (wrap_up)
  );

  timer_ovf_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (wrap_up),
    .clr_i    (flag_clr_i | irq_ack_i),
    .irq_en_i (irq_en_i),
    .flag_o   (ovf_flag_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/updown_timer_core_chk.sv
module updown_timer_core_chk #(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [SEL_W-1:0] clk_sel_i,
  input logic             count_i,
  input logic             dir_up_i,
  input logic             clear_i,
  input logic             host_wr_i,
  input logic [WIDTH-1:0] host_wdata_i,
  input logic [WIDTH-1:0] host_rdata_o,
  input logic             flag_clr_i,
  input logic             irq_ack_i,
  input logic             irq_en_i,
  input logic             top_o,
  input logic             bottom_o,
  input logic             ovf_flag_o,
  input logic             irq_o
);
  localparam logic [WIDTH-1:0] CntMax = {WIDTH{1'b1}};
  logic en;
  assign en = tick_i && (clk_sel_i != '0);

  p_load_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |=> host_rdata_o == $past(host_wdata_i));

  p_stopped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && clk_sel_i == '0) |=> $stable(host_rdata_o));

  p_no_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && !tick_i) |=> $stable(host_rdata_o));

  p_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && en && !clear_i && count_i && dir_up_i)
      |=> host_rdata_o == $past(host_rdata_o) + 1'b1);

  p_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && en && !clear_i && count_i && !dir_up_i)
      |=> host_rdata_o == $past(host_rdata_o) - 1'b1);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && en && clear_i) |=> bottom_o);

  p_top_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_wdata_i == CntMax) |=> top_o && !bottom_o);

  p_ovf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && en && !clear_i && count_i && dir_up_i && top_o) |=> ovf_flag_o);

  p_ovf_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_flag_o && !(en && count_i && dir_up_i)) |=> !ovf_flag_o);

  p_flag_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_clr_i || irq_ack_i) && !(en && !host_wr_i && !clear_i && count_i && dir_up_i))
      |=> !ovf_flag_o);

  p_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_flag_o && irq_en_i));
endmodule

bind updown_timer_core updown_timer_core_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .clk_sel_i    (clk_sel_i),
  .count_i      (count_i),
  .dir_up_i     (dir_up_i),
  .clear_i      (clear_i),
  .host_wr_i    (host_wr_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o),
  .flag_clr_i   (flag_clr_i),
  .irq_ack_i    (irq_ack_i),
  .irq_en_i     (irq_en_i),
  .top_o        (top_o),
  .bottom_o     (bottom_o),
  .ovf_flag_o   (ovf_flag_o),
  .irq_o        (irq_o)
);

// File: tb/updown_timer_core_bench.sv
module updown_timer_core_bench;
  localparam int WIDTH = 8;
  localparam int SEL_W = 3;
  localparam time ClkPeriod = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, cnt_req, dir_up, clr_req, hwr, fclr, ack, irq_en;
  logic [SEL_W-1:0] sel;
  logic [WIDTH-1:0] wdata, rdata;
  logic top, bottom, ovf, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  updown_timer_core #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_updown_timer_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .clk_sel_i(sel),
    .count_i(cnt_req), .dir_up_i(dir_up), .clear_i(clr_req),
    .host_wr_i(hwr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .flag_clr_i(fclr), .irq_ack_i(ack), .irq_en_i(irq_en),
    .top_o(top), .bottom_o(bottom), .ovf_flag_o(ovf), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input int exp);
    chk(rdata == WIDTH'(exp), req, rdata, exp);
  endtask

  task automatic idle();
    tick = 0; sel = 3'd1; cnt_req = 0; dir_up = 1; clr_req = 0;
    hwr = 0; wdata = '0; fclr = 0; ack = 0; irq_en = 0;
  endtask

  task automatic cycle();
    @(posedge clk); #1;
  endtask

  task automatic load(input int v);
    hwr = 1; wdata = WIDTH'(v); cycle(); hwr = 0;
  endtask

  task automatic up_tick();
    tick = 1; cnt_req = 1; dir_up = 1; cycle(); idle();
  endtask

  task automatic t_reset();
    chk_cnt("R1 count", 0);
    chk(bottom && !top, "R1 bottom/top", {top, bottom}, 1);
    chk(!ovf && !irq, "R1 flag", {ovf, irq}, 0);
  endtask

  task automatic t_load_read();
    load(8'h5a);
    chk_cnt("R2 load", 8'h5a);
    sel = '0; cycle();
    chk_cnt("R2 read while stopped", 8'h5a);
    idle();
  endtask

  task automatic t_priority();
    load(10);
    tick = 1; clr_req = 1; cnt_req = 1; hwr = 1; wdata = 8'd77; cycle(); idle();
    chk_cnt("R3 write over clear", 77);
    tick = 1; cnt_req = 1; dir_up = 0; hwr = 1; wdata = 8'd33; cycle(); idle();
    chk_cnt("R3 write over count", 33);
  endtask

  task automatic t_stopped();
    load(20);
    sel = '0; tick = 1; cnt_req = 1; cycle(); cycle();
    chk_cnt("R4 count blocked", 20);
    clr_req = 1; cycle(); idle();
    chk_cnt("R4 clear blocked", 20);
    for (int s = 1; s < (1 << SEL_W); s++) begin
      sel = SEL_W'(s); tick = 1; cnt_req = 1; dir_up = 1; cycle();
    end
    idle();
    chk_cnt("R4 nonzero selects count", 20 + (1 << SEL_W) - 1);
  endtask

  task automatic t_no_tick();
    load(40);
    tick = 0; cnt_req = 1; clr_req = 1; sel = 3'd5; cycle(); cycle(); idle();
    chk_cnt("R12 no tick", 40);
  endtask

  task automatic t_up_wrap();
    load(254);
    chk(!top, "R8 top below max", top, 0);
    up_tick();
    chk_cnt("R5 up step", 255);
    chk(top && !bottom, "R8 top at max", {top, bottom}, 2);
    chk(!ovf, "R9 no flag before wrap", ovf, 0);
    up_tick();
    chk_cnt("R5 up wrap", 0);
    chk(bottom && !top, "R8 bottom after wrap", {top, bottom}, 1);
    chk(ovf, "R9 flag on up wrap", ovf, 1);
    fclr = 1; cycle(); idle();
    chk(!ovf, "R10 flag write-one clear", ovf, 0);
  endtask

  task automatic t_down_wrap();
    load(1);
    tick = 1; cnt_req = 1; dir_up = 0; cycle();
    chk_cnt("R6 down step", 0);
    cycle(); idle();
    chk_cnt("R6 down wrap", 255);
    chk(!ovf, "R9 no flag on down wrap", ovf, 0);
    load(0); load(255);
    chk(!ovf, "R9 no flag on load", ovf, 0);
  endtask

  task automatic t_clear();
    load(99);
    tick = 1; clr_req = 1; cnt_req = 1; dir_up = 1; cycle(); idle();
    chk_cnt("R7 clear beats count", 0);
    load(255);
    tick = 1; clr_req = 1; cnt_req = 1; cycle(); idle();
    chk(!ovf, "R9 no flag on clear at max", ovf, 0);
  endtask

  task automatic t_flag_irq();
    load(255); up_tick();
    chk(ovf && !irq, "R11 irq masked", {ovf, irq}, 2);
    irq_en = 1; #1;
    chk(irq, "R11 irq enabled", irq, 1);
    ack = 1; cycle(); ack = 0;
    chk(!ovf && !irq, "R10 ack clears", {ovf, irq}, 0);
    load(255);
    tick = 1; cnt_req = 1; dir_up = 1; fclr = 1; cycle(); idle();
    chk(ovf, "R10 set beats clear", ovf, 1);
  endtask

  initial begin
    idle();
    repeat (3) cycle();
    t_reset();
    rst_n = 1; cycle();
    t_reset();
    t_load_read();
    t_priority();
    t_stopped();
    t_no_tick();
    t_up_wrap();
    t_down_wrap();
    t_clear();
    t_flag_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule